// File: doc/BRIEF.md
# Adaptive Bias Point Controller

This block runs once after power-up and settles the supply and bias settings of four subcircuits from the conditions the die is operating in. Out of reset it drives the highest code on every output, which is always safe. It then learns the process corner of the die, either from a stored tag or by asking an outside measurement unit. Next it latches the required frequency class and asks an outside sensor for a temperature reading. From these three facts it computes one code per subcircuit and publishes all four codes together with a one-cycle strobe.

The four codes go to the digital core voltage regulator, the oscillator voltage regulator, the amplifier current DAC and the converter current DAC. Each code is that subcircuit's base value plus separate weighted offsets for corner, temperature band and frequency class. Slow corners, hot dies and high frequency classes all push a code upward. After a finished set, a recompute request runs the sequence again from the frequency step. The outputs keep their current codes until the new set lands.

Top module: `bias_point_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, every 6-bit code reads 63 and `bias_upd`, `err`, `meas_req` and `temp_req` read 0.
- R2: With `tag_use_stored`=1 the corner comes from `stored_tag` without any request. Otherwise `meas_req` rises and stays high until `meas_valid`, and the corner is taken from `meas_tag`. Corner encoding: 0 fast, 1 typical, 2 slow, 3 invalid.
- R3: The corner step comes first. Then `freq_class` is sampled once, in the cycle before `temp_req` rises. Only after that is a temperature requested, and a change to `freq_class` after that point has no effect on the set. `meas_req` and `temp_req` are never high together.
- R4: The temperature band is cold (0) when `temp_code` < `thr_cold`, hot (2) when `temp_code` > `thr_hot`, and nominal (1) otherwise. The code is sampled in the cycle `temp_valid` is seen with `temp_req` high.
- R5: The code of slot s sits at `bias_codes[6s+5:6s]` and equals base + corner·cstep + band·tstep + class·fstep. For slots 0 to 3 (core volt, oscillator volt, amplifier current, converter current), base is 8, 12, 16, 30; cstep is 6, 5, 8, 7; tstep is 4, 3, 5, 6; fstep is 5, 6, 2, 4.
- R6: A sum above 63 gives the code 63.
- R7: All four codes change in the same cycle, and only in a cycle where `bias_upd` is high. `bias_upd` is high for exactly one cycle per computed set.
- R8: An invalid stored tag (valid low or code 3), a measured tag of 3, or no `meas_valid` within 64 cycles of `meas_req` rising each make `err` go high and stay high until reset. The codes then stay at 63, no strobe is issued and recompute has no effect.
- R9: `recompute`, sampled after a completed set, restarts at the frequency step. The previous codes stay on the outputs until the new set's strobe.
- R10: For the same class and temperature, a slower corner never yields a lower code, and a hotter band never yields a lower code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_use_stored | input | 1 | 1: take corner from stored tag, 0: measure |
| stored_tag_valid | input | 1 | Stored tag is present |
| stored_tag | input | 2 | Stored corner code |
| meas_req | output | 1 | Measurement request, held until answered |
| meas_valid | input | 1 | Measurement result available |
| meas_tag | input | 2 | Measured corner code |
| freq_class | input | 2 | Required operating frequency class |
| temp_req | output | 1 | Temperature reading request |
| temp_valid | input | 1 | Temperature reading available |
| temp_code | input | 8 | Temperature reading |
| thr_cold | input | 8 | Cold band threshold |
| thr_hot | input | 8 | Hot band threshold |
| recompute | input | 1 | Rerun from the frequency step |
| bias_codes | output | 24 | Four 6-bit bias codes, slot 0 in the low bits |
| bias_upd | output | 1 | One-cycle strobe marking a new code set |
| err | output | 1 | Sticky error: no valid corner |

## Verification
The measurement timeout is the hardest case to reach, because it needs a partner that never answers. The bench withholds `meas_valid` and counts the cycles `meas_req` stays high before `err` rises. That window has to be exactly 64 cycles. A late change of `freq_class` while the temperature request is pending shows that the class was latched earlier. The full sweep over corner, temperature edge points and class uses recompute, so every new set replaces a live set rather than the safe one.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [2:0] {
    ST_BOOT, ST_TAG, ST_MEAS, ST_FREQ, ST_TEMP, ST_CALC, ST_DONE, ST_FAIL
  } bpc_state_t;

  localparam logic [1:0] CORNER_FAST    = 2'd0;
  localparam logic [1:0] CORNER_TYP     = 2'd1;
  localparam logic [1:0] CORNER_SLOW    = 2'd2;
  localparam logic [1:0] CORNER_INVALID = 2'd3;

  localparam logic [1:0] BAND_COLD = 2'd0;
  localparam logic [1:0] BAND_NOM  = 2'd1;
  localparam logic [1:0] BAND_HOT  = 2'd2;
endpackage

// File: rtl/bpc_temp_band.sv
module bpc_temp_band #(
  parameter int TW = 8
) (
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] lim_cold,
  input  logic [TW-1:0] lim_hot,
  output logic [1:0]    band
);
  import bpc_pkg::*;

  always_comb begin
    if (temp < lim_cold)     band = BAND_COLD;
    else if (temp > lim_hot) band = BAND_HOT;
    else                     band = BAND_NOM;
  end
endmodule

// File: rtl/bpc_code_calc.sv
module bpc_code_calc #(
  parameter int          CW    = 6,
  parameter int          STW   = 4,
  parameter logic [CW-1:0]  BASE  = '0,
  parameter logic [STW-1:0] CSTEP = '0,
  parameter logic [STW-1:0] TSTEP = '0,
  parameter logic [STW-1:0] FSTEP = '0
) (
  input  logic [1:0]    corner,
  input  logic [1:0]    band,
  input  logic [1:0]    fcls,
  output logic [CW-1:0] code
);
  localparam int SW = CW + STW + 2;
  localparam logic [SW-1:0] CAP = SW'({CW{1'b1}});

  logic [SW-1:0] sum;

  always_comb begin
    sum = SW'(BASE)
        + SW'(corner) * SW'(CSTEP)
        + SW'(band)   * SW'(TSTEP)
        + SW'(fcls)   * SW'(FSTEP);
    code = (sum > CAP) ? {CW{1'b1}} : sum[CW-1:0];
  end
endmodule

// File: rtl/bpc_seq.sv
module bpc_seq #(
  parameter int MEAS_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       use_stored,
  input  logic       stored_valid,
  input  logic [1:0] stored_tag,
  input  logic       meas_valid,
  input  logic [1:0] meas_tag,
  input  logic       temp_valid,
  input  logic       recompute,
  output logic       meas_req,
  output logic       temp_req,
  output logic       ld_corner,
  output logic       take_meas,
  output logic       ld_freq,
  output logic       ld_temp,
  output logic       ld_codes,
  output logic       failed
);
  import bpc_pkg::*;

  localparam int CNTW = $clog2(MEAS_TIMEOUT + 1);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(MEAS_TIMEOUT - 1);

  bpc_state_t state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    meas_req  = 1'b0;
    temp_req  = 1'b0;
    ld_corner = 1'b0;
    take_meas = 1'b0;
    ld_freq   = 1'b0;
    ld_temp   = 1'b0;
    ld_codes  = 1'b0;
    unique case (state_q)
      ST_BOOT: state_d = ST_TAG;
      ST_TAG: begin
        if (use_stored) begin
          if (stored_valid && (stored_tag != CORNER_INVALID)) begin
            ld_corner = 1'b1;
            state_d   = ST_FREQ;
          end else begin
            state_d = ST_FAIL;
          end
        end else begin
          cnt_en  = 1'b1;
          cnt_d   = '0;
          state_d = ST_MEAS;
        end
      end
      ST_MEAS: begin
        meas_req = 1'b1;
        if (meas_valid) begin
          if (meas_tag != CORNER_INVALID) begin
            ld_corner = 1'b1;
            take_meas = 1'b1;
            state_d   = ST_FREQ;
          end else begin
            state_d = ST_FAIL;
          end
        end else if (cnt_q == CNT_LAST) begin
          state_d = ST_FAIL;
        end else begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
        end
      end
      ST_FREQ: begin
        ld_freq = 1'b1;
        state_d = ST_TEMP;
      end
      ST_TEMP: begin
        temp_req = 1'b1;
        if (temp_valid) begin
          ld_temp = 1'b1;
          state_d = ST_CALC;
        end
      end
      ST_CALC: begin
        ld_codes = 1'b1;
        state_d  = ST_DONE;
      end
      ST_DONE: if (recompute) state_d = ST_FREQ;
      ST_FAIL: state_d = ST_FAIL;
      default: state_d = ST_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign failed = (state_q == ST_FAIL);
endmodule

// File: rtl/bias_point_ctrl.sv
module bias_point_ctrl #(
  parameter int TW           = 8,
  parameter int CW           = 6,
  parameter int NSUB         = 4,
  parameter int STW          = 4,
  parameter int MEAS_TIMEOUT = 64,
  parameter logic [NSUB*CW-1:0]  BASE_V  = {6'd30, 6'd16, 6'd12, 6'd8},
  parameter logic [NSUB*STW-1:0] CSTEP_V = {4'd7, 4'd8, 4'd5, 4'd6},
  parameter logic [NSUB*STW-1:0] TSTEP_V = {4'd6, 4'd5, 4'd3, 4'd4},
  parameter logic [NSUB*STW-1:0] FSTEP_V = {4'd4, 4'd2, 4'd6, 4'd5}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tag_use_stored,
  input  logic               stored_tag_valid,
  input  logic [1:0]         stored_tag,
  output logic               meas_req,
  input  logic               meas_valid,
  input  logic [1:0]         meas_tag,
  input  logic [1:0]         freq_class,
  output logic               temp_req,
  input  logic               temp_valid,
  input  logic [TW-1:0]      temp_code,
  input  logic [TW-1:0]      thr_cold,
  input  logic [TW-1:0]      thr_hot,
  input  logic               recompute,
  output logic [NSUB*CW-1:0] bias_codes,
  output logic               bias_upd,
  output logic               err
);
  import bpc_pkg::*;

  localparam logic [NSUB*CW-1:0] SAFE_SET = {NSUB*CW{1'b1}};

  logic ld_corner, take_meas, ld_freq, ld_temp, ld_codes;
  logic [1:0] corner_q, fcls_q, band_q, band_w;
  logic [NSUB*CW-1:0] codes_q, codes_w;
  logic upd_q;

  bpc_seq #(.MEAS_TIMEOUT(MEAS_TIMEOUT)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .use_stored   (tag_use_stored),
    .stored_valid (stored_tag_valid),
    .stored_tag   (stored_tag),
    .meas_valid   (meas_valid),
    .meas_tag     (meas_tag),
    .temp_valid   (temp_valid),
    .recompute    (recompute),
    .meas_req     (meas_req),
    .temp_req     (temp_req),
    .ld_corner    (ld_corner),
    .take_meas    (take_meas),
    .ld_freq      (ld_freq),
    .ld_temp      (ld_temp),
    .ld_codes     (ld_codes),
    .failed       (err)
  );

  bpc_temp_band #(.TW(TW)) u_band (
    .temp     (temp_code),
    .lim_cold (thr_cold),
    .lim_hot  (thr_hot),
    .band     (band_w)
  );

  for (genvar s = 0; s < NSUB; s++) begin : g_slot
    bpc_code_calc #(
      .CW    (CW),
      .STW   (STW),
      .BASE  (BASE_V[s*CW +: CW]),
      .CSTEP (CSTEP_V[s*STW +: STW]),
      .TSTEP (TSTEP_V[s*STW +: STW]),
      .FSTEP (FSTEP_V[s*STW +: STW])
    ) u_calc (
      .corner (corner_q),
      .band   (band_q),
      .fcls   (fcls_q),
      .code   (codes_w[s*CW +: CW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corner_q <= CORNER_SLOW;
      fcls_q   <= '0;
      band_q   <= BAND_HOT;
      codes_q  <= SAFE_SET;
      upd_q    <= 1'b0;
    end else begin
      if (ld_corner) corner_q <= take_meas ? meas_tag : stored_tag;
      if (ld_freq)   fcls_q   <= freq_class;
      if (ld_temp)   band_q   <= band_w;
      if (ld_codes)  codes_q  <= codes_w;
      upd_q <= ld_codes;
    end
  end

  assign bias_codes = codes_q;
  assign bias_upd   = upd_q;
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
  parameter int CW   = 6,
  parameter int NSUB = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               meas_req,
  input logic               meas_valid,
  input logic               temp_req,
  input logic [NSUB*CW-1:0] bias_codes,
  input logic               bias_upd,
  input logic               err
);
  AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bias_upd |=> !bias_upd); // R7
  AST_CODES_HELD_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_upd |-> $stable(bias_codes)); // R7
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_req && temp_req)); // R3
  AST_MEAS_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_req && !meas_valid) |=> (meas_req || err)); // R2
  AST_ERR_SAFE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (bias_codes == {NSUB*CW{1'b1}})); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && !bias_upd && !temp_req)); // R8
endmodule

bind bias_point_ctrl bpc_checker #(.CW(CW), .NSUB(NSUB)) u_bpc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .meas_req   (meas_req),
  .meas_valid (meas_valid),
  .temp_req   (temp_req),
  .bias_codes (bias_codes),
  .bias_upd   (bias_upd),
  .err        (err)
);

// File: tb/bias_point_ctrl_test.sv
module bias_point_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic tag_use_stored, stored_tag_valid, meas_valid, temp_valid, recompute;
  logic [1:0] stored_tag, meas_tag, freq_class;
  logic [7:0] temp_code, thr_cold, thr_hot;
  logic meas_req, temp_req, bias_upd, err;
  logic [23:0] bias_codes;

  int n_chk = 0;
  int n_fail = 0;
  int base_t[4]  = '{8, 12, 16, 30};
  int cstep_t[4] = '{6, 5, 8, 7};
  int tstep_t[4] = '{4, 3, 5, 6};
  int fstep_t[4] = '{5, 6, 2, 4};
  int temps[6]   = '{0, 59, 60, 120, 121, 255};
  int bands[6]   = '{0, 0, 1, 1, 2, 2};
  int got[3][6][4][4];

  always #5 clk = ~clk;

  bias_point_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tag_use_stored(tag_use_stored),
    .stored_tag_valid(stored_tag_valid), .stored_tag(stored_tag),
    .meas_req(meas_req), .meas_valid(meas_valid), .meas_tag(meas_tag),
    .freq_class(freq_class), .temp_req(temp_req), .temp_valid(temp_valid),
    .temp_code(temp_code), .thr_cold(thr_cold), .thr_hot(thr_hot),
    .recompute(recompute), .bias_codes(bias_codes), .bias_upd(bias_upd),
    .err(err)
  );

  function automatic int exp_code(int s, int c, int b, int f);
    int v = base_t[s] + c * cstep_t[s] + b * tstep_t[s] + f * fstep_t[s];
    return (v > 63) ? 63 : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic use_st, input logic st_v, input logic [1:0] st_tag,
                          input logic [1:0] fc);
    rst_n = 1'b0;
    tag_use_stored = use_st; stored_tag_valid = st_v; stored_tag = st_tag;
    meas_valid = 1'b0; meas_tag = 2'd0; temp_valid = 1'b0; recompute = 1'b0;
    temp_code = 8'd0; thr_cold = 8'd60; thr_hot = 8'd120; freq_class = fc;
    repeat (3) @(negedge clk);
    chk("R1 codes in reset", int'(bias_codes), 24'hFFFFFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 codes after reset", int'(bias_codes), 24'hFFFFFF);
    chk("R1 strobe/err/req after reset", {bias_upd, err, meas_req, temp_req}, 0);
  endtask

  task automatic wait_temp_req(output bit ok);
    ok = 0;
    for (int i = 0; i < 50; i++) begin
      if (temp_req) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  // waits for temp_req, answers it, then checks the new set at its strobe
  task automatic answer_temp(input int tval, input int c, input int b, input int f,
                             input logic [23:0] prev, input string prev_req,
                             input logic late_fc, output logic [23:0] res);
    bit ok;
    wait_temp_req(ok);
    chk("R3 temp_req raised", int'(ok), 1);
    chk(prev_req, int'(bias_codes), int'(prev));
    temp_code = tval[7:0]; temp_valid = 1'b1;
    if (late_fc) freq_class = ~freq_class;
    @(negedge clk);
    temp_valid = 1'b0;
    ok = 0;
    for (int i = 0; i < 10; i++) begin
      if (bias_upd) begin ok = 1; break; end
      @(negedge clk);
    end
    chk("R7 strobe seen", int'(ok), 1);
    for (int s = 0; s < 4; s++)
      chk("R5 R4 slot code", int'(bias_codes[s*6 +: 6]), exp_code(s, c, b, f));
    res = bias_codes;
    @(negedge clk);
    chk("R7 strobe one cycle", int'(bias_upd), 0);
    chk("R7 codes hold after strobe", int'(bias_codes), int'(res));
  endtask

  initial begin
    logic [23:0] cur;
    int hi;
    bit ok;
    rst_n = 1'b0;

    // Sweep corner x temperature edge points x class, using recompute (R9)
    for (int c = 0; c < 3; c++) begin
      do_reset(1'b1, 1'b1, 2'(c), 2'd0);
      chk("R2 no meas_req on stored tag", int'(meas_req), 0);
      answer_temp(60, c, 1, 0, 24'hFFFFFF, "R1 safe codes before first set", 1'b0, cur);
      for (int t = 0; t < 6; t++)
        for (int f = 0; f < 4; f++) begin
          freq_class = 2'(f);
          recompute = 1'b1;
          @(negedge clk);
          recompute = 1'b0;
          answer_temp(temps[t], c, bands[t], f, cur, "R9 previous codes kept", 1'b0, cur);
          for (int s = 0; s < 4; s++) got[c][t][f][s] = int'(cur[s*6 +: 6]);
        end
    end
    chk("R6 saturated slot 3", got[2][5][3][3], 63);
    for (int t = 0; t < 6; t++)
      for (int f = 0; f < 4; f++)
        for (int s = 0; s < 4; s++) begin
          chk("R10 slow >= typical", int'(got[2][t][f][s] >= got[1][t][f][s]), 1);
          chk("R10 typical >= fast", int'(got[1][t][f][s] >= got[0][t][f][s]), 1);
          if (t < 5) chk("R10 hotter >= cooler", int'(got[1][t+1][f][s] >= got[1][t][f][s]), 1);
        end

    // Measured corner, late class change ignored
    do_reset(1'b0, 1'b0, 2'd0, 2'd3);
    ok = 0;
    for (int i = 0; i < 10; i++) begin
      if (meas_req) begin ok = 1; break; end
      @(negedge clk);
    end
    chk("R2 meas_req raised", int'(ok), 1);
    repeat (5) @(negedge clk);
    chk("R2 meas_req held", int'(meas_req), 1);
    meas_tag = 2'd2; meas_valid = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
    chk("R2 meas_req dropped", int'(meas_req), 0);
    answer_temp(200, 2, 2, 3, 24'hFFFFFF, "R1 safe codes before first set", 1'b1, cur);
    chk("R8 no err on good path", int'(err), 0);

    // Invalid stored tags
    do_reset(1'b1, 1'b0, 2'd1, 2'd0);
    repeat (3) @(negedge clk);
    chk("R8 err on missing stored tag", int'(err), 1);
    chk("R8 codes safe", int'(bias_codes), 24'hFFFFFF);
    do_reset(1'b1, 1'b1, 2'd3, 2'd0);
    repeat (3) @(negedge clk);
    chk("R8 err on stored code 3", int'(err), 1);
    recompute = 1'b1;
    repeat (4) @(negedge clk);
    recompute = 1'b0;
    chk("R8 recompute ignored in err", {err, temp_req, bias_upd}, 3'b100);

    // Measured code 3
    do_reset(1'b0, 1'b0, 2'd0, 2'd0);
    @(negedge clk);
    meas_tag = 2'd3; meas_valid = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
    @(negedge clk);
    chk("R8 err on measured code 3", int'(err), 1);
    chk("R8 codes safe after bad measure", int'(bias_codes), 24'hFFFFFF);

    // Timeout window
    do_reset(1'b0, 1'b0, 2'd0, 2'd0);
    hi = 0;
    for (int i = 0; i < 200; i++) begin
      if (err) break;
      if (meas_req) hi++;
      @(negedge clk);
    end
    chk("R8 timeout window cycles", hi, 64);
    chk("R8 err after timeout", int'(err), 1);
    chk("R8 no strobe after timeout", int'(bias_upd), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule